// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an external asynchronous static RAM of 512K words by 8 bits. The host hands it one word at a time: a read or a write, with a 19-bit address and, for writes, one data byte. The controller turns each request into a strobe sequence on the active-low chip, output and write enables. Every phase of that sequence is held for a whole number of clock cycles, derived at elaboration from the RAM's nanosecond timing figures and the clock period.

A read selects the chip with the output enable low for long enough to cover the access time, and samples the data on the last cycle of that window. It then deselects the chip and waits out the interval in which the RAM's outputs may still drive the bus. A write is built as three phases: a setup phase with chip select and bus drive active, a write-enable pulse, and a hold phase. Address and data stay fixed across all three. The data bus is shared, so the memory side has a separate output path, a drive-enable and an input path. When the block is idle it keeps the chip deselected, which puts the RAM in standby. The RAM is fully static, so the block has no refresh logic.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is active, and after it is released until the first request, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, host_ready is 1 and host_done is 0.
- R2: host_ready is 1 only while the controller is idle, and in that state all three strobes are 1 and mem_dq_oe is 0. A request is accepted at a rising edge where host_req and host_ready are both 1. host_ready is 0 from the cycle after acceptance until the operation ends. Requests presented while it is 0 are ignored.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for ACC cycles. mem_dq_in is captured at the edge that ends the last of those cycles.
- R4: A write (host_wr=1) runs SETUP_CYC cycles with mem_ce_n=0, mem_we_n=1 and mem_dq_oe=1, then WP cycles with mem_we_n=0, then HOLD_CYC cycles with mem_we_n=1, mem_ce_n=0 and mem_dq_oe=1. mem_oe_n stays 1 for the whole write, and mem_dq_out stays equal to the accepted write byte.
- R5: mem_we_n and mem_oe_n are never both 0, and mem_dq_oe is never 1 while mem_oe_n is 0.
- R6: After each read, the controller spends TURN cycles with every strobe at 1 and mem_dq_oe at 0 before host_ready returns to 1.
- R7: host_done is 1 for exactly one cycle per operation. After a read, host_rdata carries the captured byte from that cycle onward and keeps it until the next read completes, with writes in between leaving it unchanged.
- R8: ACC, WP and TURN are each ceil(time_ns / CLK_NS) with a minimum of 1 (55, 40 and 30 ns at 10 ns give 6, 4 and 3). host_done is seen in cycle ACC+1 after acceptance for a read and in cycle SETUP_CYC+WP+HOLD_CYC+1 for a write.
- R9: mem_addr takes the host address at acceptance and stays unchanged for as long as mem_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request strobe from the host |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Idle; a request is accepted |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data received from the RAM |

## Verification
The checker runs on every cycle and covers the following:
- read and write never overlap, and the bus is never driven while outputs are enabled;
- the setup and hold framing around the write pulse;
- address and write data stay stable while the chip is selected;
- the write pulse length and the read-to-drive gap, each measured with a counter;
- read capture happens only inside an enabled read;
- done is a single-cycle pulse.

Some properties only the bench scenarios can show. These are that the read data is correct and arrives only after the full access time, which the bench's RAM model enforces by returning corrupted bytes until enough time has elapsed. The bench also shows the exact latencies, that requests held high while busy are ignored, and that host_rdata survives later writes.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_ACC,
    PH_TURN,
    PH_WR_SU,
    PH_WR_PULSE,
    PH_WR_HOLD
  } phase_e;

  // Whole cycles that cover a time in ns, never fewer than one.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last = (cnt_q == (len - CNT_W'(1)));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   wr,
  input  logic   phase_last,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   accept,
  output logic   capture,
  output logic   advance,
  output logic   done_evt
);
  always_comb begin
    phase_d  = phase_q;
    accept   = 1'b0;
    capture  = 1'b0;
    advance  = 1'b0;
    done_evt = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req) begin
        accept  = 1'b1;
        phase_d = wr ? PH_WR_SU : PH_RD_ACC;
      end
      PH_RD_ACC: if (phase_last) begin
        capture  = 1'b1;
        done_evt = 1'b1;
        advance  = 1'b1;
        phase_d  = PH_TURN;
      end
      PH_TURN: if (phase_last) begin
        advance = 1'b1;
        phase_d = PH_IDLE;
      end
      PH_WR_SU: if (phase_last) begin
        advance = 1'b1;
        phase_d = PH_WR_PULSE;
      end
      PH_WR_PULSE: if (phase_last) begin
        advance = 1'b1;
        phase_d = PH_WR_HOLD;
      end
      PH_WR_HOLD: if (phase_last) begin
        advance  = 1'b1;
        done_evt = 1'b1;
        phase_d  = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
  import sram_strobe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_d,
  output logic   ce_n,
  output logic   oe_n,
  output logic   we_n,
  output logic   dq_oe
);
  logic ce_d, oe_d, we_d, drv_d;

  // Strobes are registered from the next phase so they leave flops cleanly.
  always_comb begin
    ce_d = 1'b1; oe_d = 1'b1; we_d = 1'b1; drv_d = 1'b0;
    unique case (phase_d)
      PH_RD_ACC:   begin ce_d = 1'b0; oe_d = 1'b0; end
      PH_WR_SU:    begin ce_d = 1'b0; drv_d = 1'b1; end
      PH_WR_PULSE: begin ce_d = 1'b0; we_d = 1'b0; drv_d = 1'b1; end
      PH_WR_HOLD:  begin ce_d = 1'b0; drv_d = 1'b1; end
      default:     begin end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0;
    end else begin
      ce_n <= ce_d; oe_n <= oe_d; we_n <= we_d; dq_oe <= drv_d;
    end
  end
endmodule

// File: rtl/sram_host_regs.sv
module sram_host_regs #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              done_evt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= host_addr;
        wdata_q <= host_wdata;
      end
      if (capture) rdata_q <= mem_dq_in;
      done_q <= done_evt;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_ACC_NS  = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_TURN_NS = 30,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned ACC_CYC  = ns_to_cycles(T_ACC_NS, CLK_NS);
  localparam int unsigned WP_CYC   = ns_to_cycles(T_WP_NS, CLK_NS);
  localparam int unsigned TURN_CYC = ns_to_cycles(T_TURN_NS, CLK_NS);
  localparam int unsigned SU_CYC   = max2(SETUP_CYC, 1);
  localparam int unsigned HD_CYC   = max2(HOLD_CYC, 1);
  localparam int unsigned MAX_CYC  =
    max2(max2(max2(ACC_CYC, WP_CYC), max2(TURN_CYC, SU_CYC)), HD_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  // Named internal events, also watched by the checker.
  phase_e           phase_q, phase_d;
  logic             accept, capture, advance, done_evt, phase_last;
  logic [CNT_W-1:0] phase_len;
  logic [CNT_W-1:0] turn_len_w, wp_len_w;

  assign turn_len_w = CNT_W'(TURN_CYC);
  assign wp_len_w   = CNT_W'(WP_CYC);
  assign host_ready = (phase_q == PH_IDLE);

  always_comb begin
    unique case (phase_q)
      PH_RD_ACC:   phase_len = CNT_W'(ACC_CYC);
      PH_TURN:     phase_len = turn_len_w;
      PH_WR_SU:    phase_len = CNT_W'(SU_CYC);
      PH_WR_PULSE: phase_len = wp_len_w;
      PH_WR_HOLD:  phase_len = CNT_W'(HD_CYC);
      default:     phase_len = CNT_W'(1);
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept | advance),
    .len(phase_len), .last(phase_last)
  );

  sram_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(host_req & host_ready), .wr(host_wr),
    .phase_last(phase_last), .phase_q(phase_q), .phase_d(phase_d),
    .accept(accept), .capture(capture), .advance(advance), .done_evt(done_evt)
  );

  sram_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  sram_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .done_evt(done_evt), .host_addr(host_addr), .host_wdata(host_wdata),
    .mem_dq_in(mem_dq_in), .addr_q(mem_addr), .wdata_q(mem_dq_out),
    .rdata_q(host_rdata), .done_q(host_done)
  );
endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_done,
  input logic              accept,
  input logic              capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic [CNT_W-1:0]  turn_len_w,
  input logic [CNT_W-1:0]  wp_len_w
);
  logic [7:0] gap_q, wlow_q;
  logic       prev_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 8'hFF; wlow_q <= '0; prev_oe_n <= 1'b1;
    end else begin
      prev_oe_n <= mem_oe_n;
      if (!prev_oe_n && mem_oe_n) gap_q <= 8'd1;
      else if (gap_q != 8'hFF)    gap_q <= gap_q + 8'd1;
      wlow_q <= mem_we_n ? 8'd0 : wlow_q + 8'd1;
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !host_ready);
  a_r3_capture_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!mem_ce_n && !mem_oe_n && mem_we_n));
  a_r4_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n)));
  a_r4_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  a_r5_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  a_r5_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  a_r6_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap_q >= 8'(turn_len_w)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
  a_r8_we_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_q >= 8'(wp_len_w)));
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .host_done(host_done),
  .accept(accept), .capture(capture), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
  .turn_len_w(turn_len_w), .wp_len_w(wp_len_w)
);

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;
  localparam int CLK = 10;
  localparam int TACC = 55, TWP = 40, TTURN = 30, SU = 1, HD = 1;

  function automatic int cyc(input int ns);
    int c;
    c = ns / CLK;
    if (c * CLK < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic logic [7:0] fill(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]};
  endfunction

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_wr = 0;
  logic [18:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ready, host_done;
  logic [7:0] host_rdata;
  logic [18:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] mem_dq_out, mem_dq_in;

  always #(CLK/2) clk = ~clk;

  sram_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model, evaluated mid-cycle ----------------
  logic [7:0] mem [int unsigned];
  logic [7:0] ref_m [int unsigned];
  logic [18:0] cur_addr = '0;
  int rd_cyc = 0, hz_cnt = 0, wl = 0;
  bit was_rd = 0, prev_we_n = 1, prev_drv = 0;
  logic [18:0] w_addr;
  logic [7:0] w_data;
  logic [7:0] ram_q = 8'h5A;
  assign mem_dq_in = ram_q;

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : fill(a);
  endfunction

  always @(negedge clk) begin
    bit rd_now;
    rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (rd_now) begin
      rd_cyc++;
      if (rd_cyc == 1) check(mem_addr == cur_addr, "R9 read address", mem_addr, cur_addr);
      ram_q = (rd_cyc * CLK >= TACC) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
    end else begin
      rd_cyc = 0;
      ram_q = 8'h5A;
    end
    if (was_rd && !rd_now) hz_cnt = cyc(TTURN);
    else if (hz_cnt > 0) hz_cnt--;
    was_rd = rd_now;
    if (mem_dq_oe)
      check(!rd_now && hz_cnt == 0 && mem_oe_n, "R5 R6 bus contention", hz_cnt, 0);
    if (!mem_ce_n && !mem_we_n) begin
      wl++;
      check(mem_oe_n, "R5 oe during write", mem_oe_n, 1);
      if (wl == 1) begin
        check(prev_drv && prev_we_n, "R4 write setup", prev_drv, 1);
        check(mem_addr == cur_addr, "R9 write address", mem_addr, cur_addr);
        w_addr = mem_addr; w_data = mem_dq_out;
      end else begin
        check(mem_addr == w_addr && mem_dq_out == w_data, "R4 stable in pulse",
              {mem_addr, mem_dq_out}, {w_addr, w_data});
      end
    end
    if (!prev_we_n && mem_we_n) begin
      check(wl * CLK >= TWP, "R8 write pulse width", wl, cyc(TWP));
      check(mem_dq_oe && !mem_ce_n && mem_addr == w_addr, "R4 write hold",
            mem_dq_oe, 1);
      mem[int'(w_addr)] = w_data;
      wl = 0;
    end
    prev_we_n = mem_we_n;
    prev_drv  = mem_dq_oe;
  end

  // ---------------- host driver ----------------
  logic [7:0] last_rd = '0;

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                       input bit hold);
    int lat, explat, t;
    bit got;
    logic [7:0] expd;
    check(host_ready, "R2 ready before request", host_ready, 1);
    host_req = 1; host_wr = wr; host_addr = a; host_wdata = d; cur_addr = a;
    expd = ref_m.exists(int'(a)) ? ref_m[int'(a)] : fill(a);
    if (wr) ref_m[int'(a)] = d;
    explat = wr ? (SU + cyc(TWP) + HD + 1) : (cyc(TACC) + 1);
    got = 0; lat = 0;
    for (int c = 1; c <= 40 && !got; c++) begin
      @(negedge clk);
      if (!hold) host_req = 0;
      else begin
        host_addr = 19'($urandom); host_wr = 1'($urandom);
        host_wdata = 8'($urandom);
      end
      if (host_done) begin
        got = 1; lat = c; host_req = 0;
      end else begin
        check(!host_ready, "R2 ready low while busy", host_ready, 0);
      end
    end
    check(got && lat == explat, "R8 completion latency", lat, explat);
    if (!wr) begin
      check(host_rdata == expd, "R3 read data", host_rdata, expd);
      last_rd = expd;
    end else begin
      check(host_rdata == last_rd, "R7 read data held over write", host_rdata, last_rd);
    end
    @(negedge clk);
    check(!host_done, "R7 done single cycle", host_done, 0);
    if (!wr) begin
      t = 1;
      while (!host_ready && t < 40) begin
        @(negedge clk); t++;
      end
      check(t == cyc(TTURN), "R6 turnaround length", t, cyc(TTURN));
    end else begin
      check(host_ready, "R2 ready after write", host_ready, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0417));
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_done,
          "R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(host_ready && mem_ce_n && !mem_dq_oe && !host_done, "R1 idle after reset",
          {host_ready, mem_ce_n, mem_dq_oe}, 3'b110);
    // directed corner cases
    do_op(0, 19'h00000, 8'h00, 0);          // unwritten location
    do_op(1, 19'h00000, 8'hA5, 0);
    do_op(0, 19'h00000, 8'h00, 0);
    do_op(1, 19'h7FFFF, 8'h3C, 0);          // top address
    do_op(0, 19'h7FFFF, 8'h00, 1);          // request held during busy
    do_op(1, 19'h7FFFF, 8'hC3, 1);
    do_op(1, 19'h12345, 8'hFF, 0);          // write right after write
    do_op(0, 19'h12345, 8'h00, 0);
    do_op(0, 19'h7FFFF, 8'h00, 0);          // read right after read
    do_op(1, 19'h00001, 8'h5A, 0);          // write right after read
    // constrained random mix over a small address pool and full range
    for (int i = 0; i < 60; i++) begin
      logic [18:0] a;
      a = ($urandom % 4 == 0) ? 19'($urandom) : 19'($urandom % 8);
      do_op(1'($urandom), a, 8'($urandom), ($urandom % 5) == 0);
    end
    for (int i = 0; i < 8; i++) do_op(0, 19'(i), 8'h00, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog timeout", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule